// File: doc/BRIEF.md
# Scanned-Display Stopwatch

This block is a stopwatch core that counts elapsed time in hundredths of a second, seconds and minutes. A single push button starts and stops the count. A reset returns the time to zero. A reference clock is divided down to a hundredths tick. Six decimal digits, each a mod-10 or mod-6 stage with a carry chain, hold the time.

The time is shown on an eight-position seven-segment display, one position at a time. A 3-bit scan counter advances on every clock and names the active position. The segment output carries the pattern for that position. Two positions hold a separator bar. The display driver wired to the outputs strobes the position given by the scan counter.

Top module: `stopwatch_scan`

## Requirements
- R1: Each press of `runstop` (a low-to-high change) flips the running state. The block comes out of reset stopped, so the first press starts the count and the next press stops it.
- R2: While stopped, every time digit and the prescaler phase hold their values, so the displayed time does not change.
- R3: `rst` is synchronous and active high. It clears all digits, the running state, the prescaler and the scan counter. While `rst` is high, `pos` reads 0 and `seg` shows the zero pattern.
- R4: While running, one hundredths tick occurs every `DIV` clocks. Each tick adds one hundredth to the time.
- R5: `runstop` passes through a two-stage synchroniser and a rising-edge detector. A press toggles the running state exactly once, however long it is held. The new state is in effect from the third clock edge that samples the press.
- R6: The carry chain works as follows. The hundredths units digit wraps after 9 and carries into the hundredths tens, which wraps after 9 and carries into the seconds units. The seconds units wrap after 9 and carry into the seconds tens, which wrap after 5 and carry into the minutes units. The minutes units wrap after 9, and the minutes tens wrap after 5. 59:59.99 rolls over to 00:00.00.
- R7: `pos` advances by one on every clock and wraps from 7 to 0. Positions 0 to 7 show, in order: minutes tens, minutes units, bar, seconds tens, seconds units, bar, hundredths tens, hundredths units.
- R8: `seg` is active high, with bit 6 as segment a down to bit 0 as segment g. The digit patterns are:
  - 0 = 1111110, 1 = 0110000, 2 = 1101101, 3 = 1111001, 4 = 0110011
  - 5 = 1011011, 6 = 1011111, 7 = 1110000, 8 = 1111111, 9 = 1111011

  A bar position shows 0000001, which lights segment g only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference and scan clock |
| rst | input | 1 | Synchronous active-high reset |
| runstop | input | 1 | Start/stop push button, asynchronous |
| pos | output | 3 | Active display position |
| seg | output | 7 | Segment pattern for the active position, a..g |

## Verification
On every cycle, the assertions check the following:
- every digit stays inside its modulus;
- the scan counter steps by one;
- a stopped watch holds its digits;
- the running state changes only on a detected press;
- reset clears the state;
- the full 59:59.99 rollover returns to zero.

Only the bench's scenarios can show the rest. These are the exact tick spacing, the press latency, and that a long press toggles once. They also cover the carry from 59.99 seconds into the minutes, and that the decoded time read back over a full scan matches a time reference built from integer arithmetic.

// File: rtl/stopwatch_scan.sv
module stopwatch_scan #(
  parameter int DIV = 2500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       runstop,
  output logic [2:0] pos,
  output logic [6:0] seg
);
  localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int NDIG = 6;

  logic [PW-1:0] pre;
  logic [2:0]    sy;
  logic          run;
  logic [3:0]    dg [NDIG];
  logic [NDIG:0] cy;
  logic [3:0]    cur;

  wire press = sy[1] & ~sy[2];
  wire tick  = run && (pre == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sy  <= '0;
      run <= 1'b0;
      pre <= '0;
      pos <= '0;
    end else begin
      sy  <= {sy[1:0], runstop};
      pos <= pos + 3'd1;
      if (press) run <= ~run;
      if (run) pre <= tick ? '0 : pre + PW'(1);
    end
  end

  assign cy[0] = tick;

  for (genvar i = 0; i < NDIG; i++) begin : g_stage
    localparam logic [3:0] LIM = (i == 3 || i == 5) ? 4'd5 : 4'd9;
    assign cy[i+1] = cy[i] && (dg[i] == LIM);
    always_ff @(posedge clk) begin
      if (rst) dg[i] <= '0;
      else if (cy[i]) dg[i] <= (dg[i] == LIM) ? 4'd0 : dg[i] + 4'd1;
    end
    p_digit_range_r6: assert property (@(posedge clk) disable iff (rst) dg[i] <= LIM);
  end

  always_comb begin
    case (pos)
      3'd0: cur = dg[5];
      3'd1: cur = dg[4];
      3'd3: cur = dg[3];
      3'd4: cur = dg[2];
      3'd6: cur = dg[1];
      3'd7: cur = dg[0];
      default: cur = 4'hF;
    endcase
  end

  function automatic logic [6:0] to_seg(input logic [3:0] d);
    case (d)
      4'd0: return 7'b1111110;
      4'd1: return 7'b0110000;
      4'd2: return 7'b1101101;
      4'd3: return 7'b1111001;
      4'd4: return 7'b0110011;
      4'd5: return 7'b1011011;
      4'd6: return 7'b1011111;
      4'd7: return 7'b1110000;
      4'd8: return 7'b1111111;
      4'd9: return 7'b1111011;
      default: return 7'b0000000;
    endcase
  endfunction

  assign seg = (pos == 3'd2 || pos == 3'd5) ? 7'b0000001 : to_seg(cur);

  p_reset_clear_r3: assert property (@(posedge clk)
    rst |=> (pos == 3'd0 && !run && dg[0] == 4'd0 && dg[1] == 4'd0 && dg[2] == 4'd0 &&
             dg[3] == 4'd0 && dg[4] == 4'd0 && dg[5] == 4'd0));

  p_scan_step_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pos == $past(pos) + 3'd1);

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable({dg[5], dg[4], dg[3], dg[2], dg[1], dg[0], pre}));

  p_one_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    !press |=> run == $past(run));

  p_full_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && dg[5] == 4'd5 && dg[4] == 4'd9 && dg[3] == 4'd5 && dg[2] == 4'd9 &&
     dg[1] == 4'd9 && dg[0] == 4'd9)
    |=> (dg[5] == 4'd0 && dg[4] == 4'd0 && dg[3] == 4'd0 && dg[2] == 4'd0 &&
         dg[1] == 4'd0 && dg[0] == 4'd0));
endmodule

// File: tb/sim_stopwatch_scan.sv
module sim_stopwatch_scan;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic runstop = 1'b0;
  logic [2:0] pos;
  logic [6:0] seg;

  int total = 0;
  int bad = 0;
  bit live = 0;

  int m_pre = 0, m_cs = 0, m_pos = 0;
  bit m_run = 0, m_s0 = 0, m_s1 = 0, m_s2 = 0, m_tk = 0;

  stopwatch_scan #(.DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .runstop(runstop), .pos(pos), .seg(seg)
  );

  always #2 clk = ~clk;

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: return 7'b1111110;
      1: return 7'b0110000;
      2: return 7'b1101101;
      3: return 7'b1111001;
      4: return 7'b0110011;
      5: return 7'b1011011;
      6: return 7'b1011111;
      7: return 7'b1110000;
      8: return 7'b1111111;
      9: return 7'b1111011;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic int undec(input logic [6:0] s);
    for (int d = 0; d < 10; d++) if (pat(d) == s) return d;
    return -1;
  endfunction

  function automatic int digit_at(input int p, input int cs);
    int mn = cs / 6000;
    int sc = (cs / 100) % 60;
    int hn = cs % 100;
    case (p)
      0: return mn / 10;
      1: return mn % 10;
      3: return sc / 10;
      4: return sc % 10;
      6: return hn / 10;
      default: return hn % 10;
    endcase
  endfunction

  function automatic logic [6:0] exp_seg(input int p, input int cs);
    if (p == 2 || p == 5) return 7'b0000001;
    return pat(digit_at(p, cs));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_cs = 0; m_pos = 0; m_run = 0; m_s0 = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      m_tk = m_run && (m_pre == DIV - 1);
      if (m_run) m_pre = m_tk ? 0 : m_pre + 1;
      if (m_tk) m_cs = (m_cs + 1) % 360000;
      if (m_s1 && !m_s2) m_run = !m_run;
      m_s2 = m_s1; m_s1 = m_s0; m_s0 = runstop;
      m_pos = (m_pos + 1) % 8;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      total++;
      if (pos !== 3'(m_pos)) begin
        bad++;
        $display("FAIL R7 pos actual=%0d expected=%0d", pos, m_pos);
      end
      total++;
      if (seg !== exp_seg(m_pos, m_cs)) begin
        bad++;
        if (m_pos == 2 || m_pos == 5)
          $display("FAIL R8 bar seg actual=%b expected=%b", seg, exp_seg(m_pos, m_cs));
        else
          $display("FAIL R4 digit seg actual=%b expected=%b cs=%0d", seg, exp_seg(m_pos, m_cs), m_cs);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic read_disp(output int v);
    int dd[8];
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      dd[pos] = undec(seg);
    end
    v = ((dd[0] * 10 + dd[1]) * 60 + dd[3] * 10 + dd[4]) * 100 + dd[6] * 10 + dd[7];
  endtask

  task automatic press(input int len);
    runstop = 1'b1;
    repeat (len) @(negedge clk);
    runstop = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int v, prev;
    repeat (3) @(negedge clk);
    live = 1;
    check(pos == 3'd0, "R3 pos in reset", pos, 0);
    check(seg == 7'b1111110, "R3 seg in reset", seg, 7'b1111110);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    read_disp(v);
    check(v == 0, "R2 idle after reset holds zero", v, 0);

    press(1);
    repeat (200) @(negedge clk);
    press(1);
    read_disp(v);
    check(v == m_cs, "R1 start/stop time", v, m_cs);
    check(v > 90 && v < 110, "R4 tick rate about one per DIV clocks", v, 100);
    prev = v;
    repeat (100) @(negedge clk);
    read_disp(v);
    check(v == prev, "R2 frozen while stopped", v, prev);

    press(60);
    repeat (100) @(negedge clk);
    press(1);
    read_disp(v);
    check(v == m_cs, "R5 long press toggles once", v, m_cs);
    check(v > prev + 40, "R5 count advanced after long press", v, prev + 50);

    press(1);
    while (m_cs < 6010) @(negedge clk);
    press(1);
    read_disp(v);
    check(v == m_cs, "R6 carry into minutes", v, m_cs);
    check(v >= 6000, "R6 reached one minute", v, 6000);

    press(1);
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(pos == 3'd0, "R3 mid-run reset pos", pos, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    read_disp(v);
    check(v == 0, "R3 reset clears time and stops", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule